// File: doc/BRIEF.md
# Microwire Serial EEPROM Model

A synthesizable behavioural model of a 2-kbit serial EEPROM that answers on a three-wire Microwire-style link: chip select, serial clock and serial data in, with a serial data output and an output-enable that stands for the high-impedance state of the pin. The link is sampled in the system clock domain. A rise of the serial clock is found by comparing it with its value one system clock earlier, and each command bit is taken on that rise. An organization input picks eight-bit items (256 of them) or sixteen-bit items (128 of them) over the same storage.

A command is a start bit, a two-bit opcode and an address, followed by data for the commands that carry it. A read streams items out without further commands for as long as chip select stays high, and the pointer wraps at the top of the array. Commands that change the storage are held until chip select falls. A self-timed programming cycle then starts, and its length is a parameter in system clocks. While it runs, raising chip select shows busy (0) on the data output, and ready (1) once it ends. Writes, erases and the whole-array commands take effect only after a write-enable command, and reset leaves the block write-disabled.

The controller is one state machine. Its states are IDLE (wait for a start bit), OPCODE (two opcode bits), ADDRESS (address bits, then decode), DATA (write data bits), STREAM (read output), HOLD (command complete, wait for chip select low), PROGRAM (self-timed cycle) and READY (cycle over, chip select still high). The transitions are:
- IDLE to OPCODE on a start bit.
- OPCODE to ADDRESS after two bits.
- ADDRESS to STREAM for a read, to DATA for a write or write-all, and to HOLD for anything else.
- DATA to HOLD after the last data bit.
- HOLD to PROGRAM when chip select falls with an accepted storage command, and to IDLE otherwise.
- PROGRAM to READY, or to IDLE when chip select is low, at the end of the cycle.
- Every other state to IDLE when chip select falls.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, sdo_oe is 0, the block is write-disabled, and every storage byte reads as 8'hFF.
- R2: While cs is high, bits are taken from sdi on each rising sclk. Zeros ahead of the first 1 are skipped and that 1 is the start bit. Two opcode bits follow, then the address most significant bit first: 8 bits when org is 0 and 7 bits when org is 1.
- R3: Opcode 2'b10 reads. The sclk rise that takes the last address bit drives a 0 dummy bit. Each following rise drives one data bit, most significant first: 8 bits per item when org is 0 and 16 when org is 1. Word a is byte 2a as its upper half and byte 2a+1 as its lower half.
- R4: After the last bit of an item the pointer steps by one and the next item follows at once. Byte address 255 wraps to 0, and word address 127 wraps to 0.
- R5: Opcode 2'b01 followed by 8 or 16 data bits (most significant first) replaces the addressed item when chip select falls, with no prior erase.
- R6: Programming lasts exactly PROG_CYCLES system clocks, starting with the clock that samples cs low. During that time cs high gives sdo_oe=1 and sdo=0. Afterwards, while cs stays high, sdo_oe=1 and sdo=1.
- R7: Opcode 2'b11 sets the addressed item to all ones.
- R8: Opcode 2'b00 with the two top address bits 2'b01 writes the following data to every item. With 2'b10 it sets every item to all ones.
- R9: Opcode 2'b00 with top address bits 2'b11 enables programming, and with 2'b00 disables it. While disabled, write, erase, write-all and erase-all change nothing and start no busy period.
- R10: sdo_oe is 0 whenever cs is low. Dropping cs before a command is complete discards it. sclk activity during programming does not change the busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| org | input | 1 | Organization: 0 = 8-bit items, 1 = 16-bit items |
| sdo | output | 1 | Serial data out / busy-ready flag |
| sdo_oe | output | 1 | Output enable; 0 models high impedance |

## Verification
The hardest situations to reach are the two wrap points of a streaming read and the split between byte and word views of the same storage. Reaching them needs known, distinct values at the top and bottom addresses, so the stimulus writes those first. It then reads bytes across address 255 and words across address 127, and reads a freshly written word back as two bytes. A second hard case is the busy period while the serial clock keeps running. The stimulus toggles sclk and sdi throughout a programming cycle and counts the busy samples against the parameter.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDRESS, ST_DATA,
        ST_STREAM, ST_HOLD, ST_PROGRAM, ST_READY
    } mw_state_t;

    typedef enum logic [2:0] {
        PG_NONE, PG_WRITE, PG_ERASE, PG_WRALL, PG_ERALL
    } pg_op_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] EXT_ENABLE  = 2'b11;
    localparam logic [1:0] EXT_DISABLE = 2'b00;
    localparam logic [1:0] EXT_FILL    = 2'b01;
    localparam logic [1:0] EXT_CLEAR   = 2'b10;
endpackage

// File: rtl/mw_sclk_edge.sv
module mw_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLES);
        end else if (busy) begin
            if (remain == CW'(1)) busy <= 1'b0;
            remain <= remain - CW'(1);
        end
    end

    assign done = busy && (remain == CW'(1));
endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
#(
    parameter int BYTE_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  pg_op_t             op,
    input  logic               wide,
    input  logic [BYTE_AW-1:0] addr,
    input  logic [15:0]        wdata,
    input  logic [BYTE_AW-1:0] rd_addr,
    output logic [15:0]        rd_data
);
    localparam int DEPTH = 1 << BYTE_AW;
    localparam int WAW   = BYTE_AW - 1;

    logic [7:0] mem [DEPTH];

    logic [BYTE_AW-1:0] hi_idx, lo_idx, rhi_idx, rlo_idx;
    assign hi_idx  = {addr[WAW-1:0], 1'b0};
    assign lo_idx  = {addr[WAW-1:0], 1'b1};
    assign rhi_idx = {rd_addr[WAW-1:0], 1'b0};
    assign rlo_idx = {rd_addr[WAW-1:0], 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            unique case (op)
                PG_WRITE: begin
                    if (wide) begin
                        mem[hi_idx] <= wdata[15:8];
                        mem[lo_idx] <= wdata[7:0];
                    end else begin
                        mem[addr] <= wdata[7:0];
                    end
                end
                PG_ERASE: begin
                    if (wide) begin
                        mem[hi_idx] <= 8'hFF;
                        mem[lo_idx] <= 8'hFF;
                    end else begin
                        mem[addr] <= 8'hFF;
                    end
                end
                PG_WRALL: begin
                    for (int i = 0; i < DEPTH; i++)
                        mem[i] <= (wide && (i % 2 == 0)) ? wdata[15:8] : wdata[7:0];
                end
                PG_ERALL: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (wide) rd_data = {mem[rhi_idx], mem[rlo_idx]};
        else      rd_data = {mem[rd_addr], 8'h00};
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int BYTE_AW     = 8,
    parameter int PROG_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    input  logic org,
    output logic sdo,
    output logic sdo_oe
);
    localparam int WAW   = BYTE_AW - 1;
    localparam int CNT_W = 5;

    mw_state_t state, state_nxt;

    logic               rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [1:0]         opc;
    logic [BYTE_AW-1:0] addr_sr;
    logic [15:0]        data_sr;
    logic [BYTE_AW-1:0] ptr;
    logic [15:0]        rd_sr;
    logic               sdo_q;
    logic               wen;
    pg_op_t             pend_op;

    logic               tmr_busy, tmr_done, prog_go;
    logic [15:0]        rd_data;
    logic [BYTE_AW-1:0] rd_addr;

    // derived serial fields
    logic [BYTE_AW-1:0] addr_in, item_in, ptr_next;
    logic [15:0]        data_in;
    logic [1:0]         top2;
    logic [CNT_W-1:0]   aw_last, dw_last;
    logic               tick;

    assign tick     = rise && cs;
    assign addr_in  = {addr_sr[BYTE_AW-2:0], sdi};
    assign item_in  = org ? {1'b0, addr_in[WAW-1:0]} : addr_in;
    assign top2     = org ? addr_in[WAW-1:WAW-2] : addr_in[BYTE_AW-1:BYTE_AW-2];
    assign data_in  = {data_sr[14:0], sdi};
    assign aw_last  = org ? CNT_W'(WAW - 1) : CNT_W'(BYTE_AW - 1);
    assign dw_last  = org ? CNT_W'(15) : CNT_W'(7);
    assign ptr_next = org ? {1'b0, WAW'(ptr[WAW-1:0] + 1'b1)} : ptr + 1'b1;
    assign rd_addr  = (state == ST_ADDRESS) ? item_in : ptr_next;
    assign prog_go  = (state == ST_HOLD) && !cs && (pend_op != PG_NONE);

    mw_sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_go),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    mw_store #(.BYTE_AW(BYTE_AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_go),
        .op      (pend_op),
        .wide    (org),
        .addr    (ptr),
        .wdata   (data_sr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (tick && sdi) state_nxt = ST_OPCODE;
            ST_OPCODE: begin
                if (!cs) state_nxt = ST_IDLE;
                else if (tick && bit_cnt == CNT_W'(1)) state_nxt = ST_ADDRESS;
            end
            ST_ADDRESS: begin
                if (!cs) state_nxt = ST_IDLE;
                else if (tick && bit_cnt == aw_last) begin
                    if (opc == OPC_READ) state_nxt = ST_STREAM;
                    else if (opc == OPC_WRITE) state_nxt = ST_DATA;
                    else if (opc == OPC_EXT && top2 == EXT_FILL) state_nxt = ST_DATA;
                    else state_nxt = ST_HOLD;
                end
            end
            ST_DATA: begin
                if (!cs) state_nxt = ST_IDLE;
                else if (tick && bit_cnt == dw_last) state_nxt = ST_HOLD;
            end
            ST_STREAM:  if (!cs) state_nxt = ST_IDLE;
            ST_HOLD:    if (!cs) state_nxt = (pend_op != PG_NONE) ? ST_PROGRAM : ST_IDLE;
            ST_PROGRAM: if (tmr_done) state_nxt = cs ? ST_READY : ST_IDLE;
            ST_READY:   if (!cs) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            opc     <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            ptr     <= '0;
            rd_sr   <= '0;
            sdo_q   <= 1'b0;
            wen     <= 1'b0;
            pend_op <= PG_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    pend_op <= PG_NONE;
                end
                ST_OPCODE: if (tick) begin
                    opc     <= {opc[0], sdi};
                    bit_cnt <= (bit_cnt == CNT_W'(1)) ? '0 : bit_cnt + 1'b1;
                end
                ST_ADDRESS: if (tick) begin
                    addr_sr <= addr_in;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == aw_last) begin
                        bit_cnt <= '0;
                        ptr     <= item_in;
                        rd_sr   <= rd_data;
                        sdo_q   <= 1'b0;
                        if (opc == OPC_ERASE && wen) pend_op <= PG_ERASE;
                        if (opc == OPC_EXT) begin
                            if (top2 == EXT_ENABLE)  wen <= 1'b1;
                            if (top2 == EXT_DISABLE) wen <= 1'b0;
                            if (top2 == EXT_CLEAR && wen) pend_op <= PG_ERALL;
                        end
                    end
                end
                ST_DATA: if (tick) begin
                    data_sr <= data_in;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == dw_last) begin
                        bit_cnt <= '0;
                        if (wen) pend_op <= (opc == OPC_WRITE) ? PG_WRITE : PG_WRALL;
                    end
                end
                ST_STREAM: if (tick) begin
                    sdo_q <= rd_sr[15];
                    rd_sr <= {rd_sr[14:0], 1'b0};
                    if (bit_cnt == dw_last) begin
                        bit_cnt <= '0;
                        ptr     <= ptr_next;
                        rd_sr   <= rd_data;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_HOLD:    ;
                ST_PROGRAM: ;
                ST_READY:   ;
                default:    ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo_oe = cs && (state == ST_STREAM || state == ST_PROGRAM || state == ST_READY);
        unique case (state)
            ST_STREAM: sdo = sdo_q;
            ST_READY:  sdo = 1'b1;
            default:   sdo = 1'b0;
        endcase
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      sdo,
    input logic      sdo_oe,
    input mw_state_t state,
    input logic      tmr_busy,
    input logic      tmr_done,
    input logic      prog_go,
    input logic      wen
);
    assert_hiz_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sdo_oe);

    assert_busy_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROGRAM && cs) |-> (sdo_oe && !sdo));

    assert_ready_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && cs) |-> (sdo_oe && sdo));

    assert_prog_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wen);

    assert_start_makes_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> (tmr_busy && state == ST_PROGRAM));

    assert_timer_in_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> state == ST_PROGRAM);

    assert_prog_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROGRAM && !tmr_done) |=> state == ST_PROGRAM);

    assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && $past(state) == ST_ADDRESS) |-> !sdo);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .state    (state),
    .tmr_busy (tmr_busy),
    .tmr_done (tmr_done),
    .prog_go  (prog_go),
    .wen      (wen)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
    localparam int N = 20;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b0;
    logic sdo, sdo_oe;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] ref_mem [256];
    logic ref_wen = 1'b0;

    always #2 clk = ~clk;

    mw_eeprom #(.BYTE_AW(8), .PROG_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .org(org), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // every clock: deselected means high impedance (R10)
    always @(posedge clk) begin
        #1;
        if (rst_n && !cs) chk("R10 hiz while deselected", 32'(sdo_oe), 32'd0);
    end

    function automatic logic [15:0] ref_item(input logic o, input logic [7:0] a);
        return o ? {ref_mem[{a[6:0], 1'b0}], ref_mem[{a[6:0], 1'b1}]} : {8'h00, ref_mem[a]};
    endfunction

    task automatic ref_put(input logic o, input logic [7:0] a, input logic [15:0] v);
        if (o) begin
            ref_mem[{a[6:0], 1'b0}] = v[15:8];
            ref_mem[{a[6:0], 1'b1}] = v[7:0];
        end else ref_mem[a] = v[7:0];
    endtask

    task automatic bitclk(input logic din, output logic dout);
        @(negedge clk); sdi = din; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
        #1 dout = sdo;
    endtask

    task automatic select_dev(input logic o);
        @(negedge clk); org = o; cs = 1'b1;
    endtask

    task automatic deselect;
        @(negedge clk); cs = 1'b0; sdi = 1'b0;
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [7:0] a, input int zeros,
                            output logic last);
        logic d;
        int n;
        n = org ? 7 : 8;
        for (int i = 0; i < zeros; i++) bitclk(1'b0, d);
        bitclk(1'b1, d);
        bitclk(op[1], d);
        bitclk(op[0], d);
        for (int i = n - 1; i >= 0; i--) bitclk(a[i], d);
        last = d;
    endtask

    task automatic send_data(input logic [15:0] v);
        logic d;
        for (int i = (org ? 15 : 7); i >= 0; i--) bitclk(v[i], d);
    endtask

    // drop cs, raise it again and measure the busy period
    task automatic finish_prog(input string req, input logic expect_prog, input logic toggle);
        int cnt;
        deselect();
        @(negedge clk); cs = 1'b1;
        #1;
        cnt = 0;
        if (expect_prog) begin
            while (sdo_oe === 1'b1 && sdo === 1'b0 && cnt < 1000) begin
                cnt++;
                @(negedge clk);
                if (toggle) begin sclk = ~sclk; sdi = ~sdi; end
                #1;
            end
            chk({req, " busy cycles"}, cnt, N);
            sclk = 1'b0;
            chk({req, " ready flag"}, {30'd0, sdo_oe, sdo}, 32'd3);
        end else begin
            repeat (3) @(negedge clk);
            #1 chk({req, " no busy"}, 32'(sdo_oe), 32'd0);
        end
        deselect();
    endtask

    task automatic do_read(input string req, input logic o, input logic [7:0] a,
                           input int items, input int zeros);
        logic d;
        logic [15:0] got;
        logic [7:0] p;
        p = a;
        select_dev(o);
        send_hdr(2'b10, a, zeros, d);
        chk({req, " dummy bit"}, {31'd0, d}, 32'd0);
        chk({req, " output enabled"}, 32'(sdo_oe), 32'd1);
        for (int k = 0; k < items; k++) begin
            got = '0;
            for (int i = 0; i < (o ? 16 : 8); i++) begin
                bitclk(1'b0, d);
                got = {got[14:0], d};
            end
            chk(req, 32'(got), 32'(ref_item(o, p)));
            p = o ? {1'b0, 7'(p[6:0] + 1'b1)} : 8'(p + 1'b1);
        end
        deselect();
        #1 chk("R10 hiz after read", 32'(sdo_oe), 32'd0);
    endtask

    task automatic do_write(input string req, input logic o, input logic [7:0] a,
                            input logic [15:0] v, input logic toggle);
        logic d;
        select_dev(o);
        send_hdr(2'b01, a, 0, d);
        send_data(v);
        finish_prog(req, ref_wen, toggle);
        if (ref_wen) ref_put(o, a, v);
    endtask

    task automatic do_erase(input string req, input logic o, input logic [7:0] a);
        logic d;
        select_dev(o);
        send_hdr(2'b11, a, 0, d);
        finish_prog(req, ref_wen, 1'b0);
        if (ref_wen) ref_put(o, a, 16'hFFFF);
    endtask

    task automatic do_ext(input string req, input logic o, input logic [1:0] code,
                          input logic [15:0] v);
        logic d;
        logic [7:0] a;
        a = o ? {1'b0, code, 5'd0} : {code, 6'd0};
        select_dev(o);
        send_hdr(2'b00, a, 0, d);
        if (code == 2'b01) send_data(v);
        if (code == 2'b11) ref_wen = 1'b1;
        if (code == 2'b00) ref_wen = 1'b0;
        if (code == 2'b01 || code == 2'b10) begin
            finish_prog(req, ref_wen, 1'b0);
            if (ref_wen)
                for (int i = 0; i < 256; i++)
                    ref_mem[i] = (code == 2'b10) ? 8'hFF : ((o && i % 2 == 0) ? v[15:8] : v[7:0]);
        end else begin
            finish_prog(req, 1'b0, 1'b0);
        end
    endtask

    initial begin
        logic d;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        chk("R1 reset sdo_oe", 32'(sdo_oe), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        do_write("R9 R1 write while disabled", 1'b0, 8'd5, 16'h00A5, 1'b0);
        do_read("R1 reset contents", 1'b0, 8'd5, 2, 0);

        do_ext("R9 enable", 1'b0, 2'b11, 16'h0);
        do_write("R5 R6 byte write", 1'b0, 8'd5, 16'h00A5, 1'b0);
        do_read("R3 byte read", 1'b0, 8'd5, 1, 0);

        do_write("R5 word write", 1'b1, 8'd3, 16'h1234, 1'b0);
        do_read("R3 word read", 1'b1, 8'd3, 1, 0);
        do_read("R3 R4 word as bytes", 1'b0, 8'd6, 2, 0);

        do_write("R5 top byte", 1'b0, 8'd255, 16'h003C, 1'b0);
        do_write("R5 bottom byte", 1'b0, 8'd0, 16'h00C3, 1'b0);
        do_read("R4 byte wrap", 1'b0, 8'd254, 4, 0);
        do_read("R4 word wrap", 1'b1, 8'd127, 2, 0);

        do_write("R5 overwrite", 1'b0, 8'd5, 16'h005A, 1'b0);
        do_read("R5 overwrite read", 1'b0, 8'd5, 1, 0);

        do_erase("R7 byte erase", 1'b0, 8'd5);
        do_read("R7 byte erased", 1'b0, 8'd5, 1, 0);
        do_erase("R7 word erase", 1'b1, 8'd3);
        do_read("R7 word erased", 1'b1, 8'd3, 1, 0);

        do_read("R2 leading zeros", 1'b0, 8'd0, 1, 3);

        // R10: abort a write part-way through the address
        select_dev(1'b0);
        bitclk(1'b1, d); bitclk(1'b0, d); bitclk(1'b1, d);
        bitclk(1'b0, d); bitclk(1'b0, d); bitclk(1'b0, d);
        finish_prog("R10 aborted write", 1'b0, 1'b0);
        do_read("R10 abort left data", 1'b0, 8'd0, 1, 0);

        do_write("R10 sclk during programming", 1'b0, 8'd10, 16'h0077, 1'b1);
        do_read("R10 toggled write read", 1'b0, 8'd10, 1, 0);

        do_ext("R8 write-all", 1'b1, 2'b01, 16'hBEEF);
        do_read("R8 write-all bytes", 1'b0, 8'd100, 3, 0);
        do_read("R8 write-all words", 1'b1, 8'd64, 2, 0);
        do_ext("R8 erase-all", 1'b0, 2'b10, 16'h0);
        do_read("R8 erase-all read", 1'b1, 8'd10, 2, 0);

        do_write("R5 before disable", 1'b0, 8'd1, 16'h0011, 1'b0);
        do_ext("R9 disable", 1'b0, 2'b00, 16'h0);
        do_write("R9 write ignored", 1'b0, 8'd1, 16'h0000, 1'b0);
        do_erase("R9 erase ignored", 1'b0, 8'd1);
        do_ext("R9 erase-all ignored", 1'b0, 2'b10, 16'h0);
        do_read("R9 data kept", 1'b0, 8'd1, 1, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule